// File: doc/BRIEF.md
# Page-Addressed Monochrome Display Controller

This block holds the picture for a 128 by 64 monochrome panel in an internal store of one bit per pixel. The store is arranged as eight horizontal bands ("pages") of eight rows each. Each stored byte covers one column of a page, and its bit k is row k of that band. Software drives the block through a small register window.

A mode register decides what a write to the shared port register means. In command mode, such a write selects a page. In data mode, it stores a column byte at the current page and column, and the column then advances. A separate page register selects a page in every mode. Page-select codes are the values 0xB0 to 0xB7. The column resets to zero whenever a page is selected.

A scanout engine reads pixels through a valid/ready pixel port. Each response is the 24-bit colour of the requested pixel, scaled by a 3-bit brightness level. A response may be held back by the consumer. While it is held, no new request is accepted.

Top module: `mono_panel_ctrl`

## Requirements
- R1: After reset the mode is idle, the page and column are 0, every pixel reads as unlit, `pix_rsp_valid` is 0 and `pix_req_ready` is 1.
- R2: A write to offset 0x1AC selects the mode. The value 0x00100011 selects data mode, 0x00104011 selects command mode, and any other value selects idle mode. In idle mode, writes to the port register 0x1C0 change neither the store nor the page and column.
- R3: In command mode, a port write whose full 32-bit value is in 0xB0..0xB7 selects page (value − 0xB0) and sets the column to 0. Other command values are ignored.
- R4: A write of 0xB0..0xB7 to offset 0x1BC selects the page and clears the column in any mode. Out-of-range values written there are ignored.
- R5: In data mode, a port write stores `wr_data[7:0]` at byte index page*128 + column and then increments the column. This holds even when the value looks like a page code.
- R6: Once the column has reached 128, further data writes are dropped and the column stays at 128. Nothing spills into the next page.
- R7: Pixel (x, y) is bit (y mod 8) of byte x + (y div 8)*128.
- R8: A lit pixel returns colour 0xE0E0FF and an unlit pixel returns 0. Each 8-bit component is replaced by floor(component*level/7), where level is `bright_level` sampled with the request. In `pix_rgb`, bits [23:16] and [15:8] carry the 0xE0 components and bits [7:0] carries the 0xFF component.
- R9: A request is accepted when `pix_req_valid` and `pix_req_ready` are both high. `pix_req_ready` is `!pix_rsp_valid || pix_rsp_ready`. The response is valid on the next cycle. While `pix_rsp_valid` is high and `pix_rsp_ready` is low, the response and its colour hold still.
- R10: `rd_data` is 0x00400000 (ready) when `rd_addr` is 0x180 and 0 for any other address. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 12 | Register read offset |
| rd_data | output | 32 | Register read value |
| bright_level | input | 3 | Brightness level 0..7 |
| pix_req_valid | input | 1 | Pixel request valid |
| pix_req_ready | output | 1 | Pixel request accepted this cycle |
| pix_x | input | 7 | Pixel column 0..127 |
| pix_y | input | 6 | Pixel row 0..63 |
| pix_rsp_valid | output | 1 | Pixel response valid |
| pix_rsp_ready | input | 1 | Consumer takes the response |
| pix_rgb | output | 24 | Scaled pixel colour |

## Verification
A wrong page or column register cannot be seen directly. It shows up only as a lit pixel at the wrong place, or as a missing pixel, when that position is later fetched through the pixel port. For that reason, every stored byte is compared against a bench model of the store, and randomly chosen pixels are read back. A wrong mode decode or a column that wraps past 127 corrupts a later write rather than the current one. Directed sequences therefore write, then read back a position the error would have disturbed, one cycle after the write. Brightness and back-pressure faults appear on the very next response.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_DATA = 2'd2
  } pmode_e;

  localparam logic [31:0] KEY_DATA      = 32'h0010_0011;
  localparam logic [31:0] KEY_CMD       = 32'h0010_4011;
  localparam logic [31:0] PAGE_CMD_BASE = 32'h0000_00B0;
  localparam logic [31:0] STATUS_READY  = 32'h0040_0000;

  localparam logic [11:0] OFS_STATUS = 12'h180;
  localparam logic [11:0] OFS_MODE   = 12'h1AC;
  localparam logic [11:0] OFS_PAGE   = 12'h1BC;
  localparam logic [11:0] OFS_PORT   = 12'h1C0;

  localparam logic [23:0] LIT_RGB = 24'hE0E0FF;
endpackage

// File: rtl/lcdp_addr_ctl.sv
module lcdp_addr_ctl
  import lcdp_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  parameter int AW    = 12,
  parameter int FB_AW = $clog2(COLS * PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_waddr,
  output logic [7:0]       fb_wdata
);
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int COL_W  = $clog2(COLS) + 1;
  localparam logic [COL_W-1:0] COL_END = COL_W'(COLS);

  pmode_e            mode_q, mode_d;
  logic [PAGE_W-1:0] page_q, page_idx;
  logic [COL_W-1:0]  col_q;
  logic hit_mode, hit_page, hit_port, page_code, page_sel_evt, store_evt;

  always_comb begin
    hit_mode  = wr_en && (wr_addr == AW'(OFS_MODE));
    hit_page  = wr_en && (wr_addr == AW'(OFS_PAGE));
    hit_port  = wr_en && (wr_addr == AW'(OFS_PORT));
    page_code = (wr_data >= PAGE_CMD_BASE) &&
                (wr_data < (PAGE_CMD_BASE + 32'(PAGES)));
    page_idx  = PAGE_W'(wr_data - PAGE_CMD_BASE);
    page_sel_evt = page_code && (hit_page || (hit_port && mode_q == MODE_CMD));
    store_evt = hit_port && (mode_q == MODE_DATA) && (col_q < COL_END);
    if (wr_data == KEY_DATA)     mode_d = MODE_DATA;
    else if (wr_data == KEY_CMD) mode_d = MODE_CMD;
    else                         mode_d = MODE_IDLE;
  end

  always_comb begin
    fb_we    = store_evt;
    fb_waddr = FB_AW'(page_q) * FB_AW'(COLS) + FB_AW'(col_q);
    fb_wdata = wr_data[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      page_q <= '0;
      col_q  <= '0;
    end else begin
      if (hit_mode) mode_q <= mode_d;
      if (page_sel_evt) begin
        page_q <= page_idx;
        col_q  <= '0;
      end else if (store_evt) begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // R6
  col_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_END);
  // R6
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_port && mode_q == MODE_DATA && col_q == COL_END) |=> col_q == COL_END);
  // R5
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> col_q == $past(col_q) + 1'b1);
  // R3
  page_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_sel_evt |=> (col_q == '0) && (page_q == $past(page_idx)));
endmodule

// File: rtl/lcdp_frame_mem.sv
module lcdp_frame_mem #(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  parameter int FB_AW = $clog2(COLS * PAGES),
  parameter int XW    = $clog2(COLS),
  parameter int YW    = $clog2(PAGES * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FB_AW-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             rd_en,
  input  logic [XW-1:0]    rd_x,
  input  logic [YW-1:0]    rd_y,
  output logic             pix_q
);
  localparam int DEPTH = COLS * PAGES;

  logic [7:0]       mem [DEPTH];
  logic [FB_AW-1:0] rd_idx;
  logic [2:0]       rd_bit;

  always_comb begin
    rd_idx = FB_AW'(rd_x) + FB_AW'(rd_y >> 3) * FB_AW'(COLS);
    rd_bit = rd_y[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      pix_q <= 1'b0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (rd_en) pix_q <= mem[rd_idx][rd_bit];
    end
  end
endmodule

// File: rtl/lcdp_shade.sv
module lcdp_shade
  import lcdp_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             lit,
  input  logic [LVL_W-1:0] level,
  output logic [23:0]      rgb
);
  localparam int PW = 8 + LVL_W;
  localparam logic [PW-1:0] LVL_MAX = PW'((1 << LVL_W) - 1);

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [PW-1:0] prod, quot;
    always_comb begin
      prod = PW'(LIT_RGB[c*8 +: 8]) * PW'(level);
      quot = prod / LVL_MAX;
      rgb[c*8 +: 8] = lit ? quot[7:0] : 8'h00;
    end
  end
endmodule

// File: rtl/mono_panel_ctrl.sv
module mono_panel_ctrl
  import lcdp_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  parameter int AW    = 12,
  parameter int LVL_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [AW-1:0]              rd_addr,
  output logic [31:0]                rd_data,
  input  logic [LVL_W-1:0]           bright_level,
  input  logic                       pix_req_valid,
  output logic                       pix_req_ready,
  input  logic [$clog2(COLS)-1:0]    pix_x,
  input  logic [$clog2(PAGES*8)-1:0] pix_y,
  output logic                       pix_rsp_valid,
  input  logic                       pix_rsp_ready,
  output logic [23:0]                pix_rgb
);
  localparam int XW    = $clog2(COLS);
  localparam int YW    = $clog2(PAGES * 8);
  localparam int FB_AW = $clog2(COLS * PAGES);

  logic             fb_we;
  logic [FB_AW-1:0] fb_waddr;
  logic [7:0]       fb_wdata;
  logic             req_fire, rsp_valid_q, pix_bit;
  logic [LVL_W-1:0] lvl_q;

  lcdp_addr_ctl #(.COLS(COLS), .PAGES(PAGES), .AW(AW), .FB_AW(FB_AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata)
  );

  lcdp_frame_mem #(.COLS(COLS), .PAGES(PAGES), .FB_AW(FB_AW), .XW(XW), .YW(YW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(fb_we), .waddr(fb_waddr), .wdata(fb_wdata),
    .rd_en(req_fire), .rd_x(pix_x), .rd_y(pix_y), .pix_q(pix_bit)
  );

  lcdp_shade #(.LVL_W(LVL_W)) u_shade (
    .lit(pix_bit), .level(lvl_q), .rgb(pix_rgb)
  );

  always_comb begin
    pix_req_ready = !rsp_valid_q || pix_rsp_ready;
    req_fire      = pix_req_valid && pix_req_ready;
    pix_rsp_valid = rsp_valid_q;
    rd_data       = (rd_addr == AW'(OFS_STATUS)) ? STATUS_READY : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      lvl_q       <= '0;
    end else begin
      if (req_fire) begin
        rsp_valid_q <= 1'b1;
        lvl_q       <= bright_level;
      end else if (pix_rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rsp_valid && !pix_rsp_ready) |=> (pix_rsp_valid && $stable(pix_rgb)));
  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req_valid && pix_req_ready) |=> pix_rsp_valid);
  // R8
  dark_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rsp_valid && lvl_q == '0) |-> pix_rgb == 24'h0);
endmodule

// File: tb/tb_mono_panel_ctrl.sv
module tb_mono_panel_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_STAT = 12'h180, A_MODE = 12'h1AC,
                          A_PAGE = 12'h1BC, A_PORT = 12'h1C0;
  localparam logic [31:0] K_DATA = 32'h0010_0011, K_CMD = 32'h0010_4011;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [2:0] bright_level = 0;
  logic pix_req_valid = 0, pix_req_ready, pix_rsp_valid, pix_rsp_ready = 1;
  logic [6:0] pix_x = 0;
  logic [5:0] pix_y = 0;
  logic [23:0] pix_rgb;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] fb_m [1024];
  int m_mode = 0, m_page = 0, m_col = 0;

  mono_panel_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bright_level(bright_level),
    .pix_req_valid(pix_req_valid), .pix_req_ready(pix_req_ready),
    .pix_x(pix_x), .pix_y(pix_y), .pix_rsp_valid(pix_rsp_valid),
    .pix_rsp_ready(pix_rsp_ready), .pix_rgb(pix_rgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_rgb(bit lit, int lvl);
    int a, b;
    if (!lit) return 24'h0;
    a = (224 * lvl) / 7;
    b = (255 * lvl) / 7;
    return {a[7:0], a[7:0], b[7:0]};
  endfunction

  function automatic bit exp_pix(int x, int y);
    logic [7:0] v;
    v = fb_m[x + (y / 8) * 128];
    return v[y % 8];
  endfunction

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == A_MODE) m_mode = (d == K_DATA) ? 2 : (d == K_CMD) ? 1 : 0;
    else if (a == A_PAGE) begin
      if (d >= 32'hB0 && d <= 32'hB7) begin m_page = int'(d - 32'hB0); m_col = 0; end
    end else if (a == A_PORT) begin
      if (m_mode == 1 && d >= 32'hB0 && d <= 32'hB7) begin
        m_page = int'(d - 32'hB0); m_col = 0;
      end else if (m_mode == 2 && m_col < 128) begin
        fb_m[m_page * 128 + m_col] = d[7:0];
        m_col++;
      end
    end
  endtask

  task automatic pix_check(int x, int y, int lvl, string req);
    @(negedge clk);
    pix_x = 7'(x); pix_y = 6'(y); bright_level = 3'(lvl);
    pix_req_valid = 1; pix_rsp_ready = 1;
    @(negedge clk);
    pix_req_valid = 0;
    check(req, {31'h0, pix_rsp_valid}, 32'h1);
    check(req, {8'h0, pix_rgb}, {8'h0, exp_rgb(exp_pix(x, y), lvl)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int i = 0; i < 1024; i++) fb_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    check("R1 rsp_valid", {31'h0, pix_rsp_valid}, 0);
    check("R1 req_ready", {31'h0, pix_req_ready}, 1);
    pix_check(0, 0, 7, "R1 pixel");
    pix_check(127, 63, 7, "R1 pixel");
    // R10 status read
    rd_addr = A_STAT; #1 check("R10 status", rd_data, 32'h0040_0000);
    rd_addr = A_MODE; #1 check("R10 other", rd_data, 32'h0);

    // R5 R7 data store at page 2 column 0
    reg_write(A_MODE, K_DATA);
    reg_write(A_PAGE, 32'hB2);
    reg_write(A_PORT, 32'h0000_00A5);
    pix_check(0, 16, 7, "R7 bit0 lit");
    pix_check(0, 17, 7, "R7 bit1 dark");
    pix_check(0, 23, 7, "R7 bit7 lit");

    // R3 command page select, R2 mode keys
    reg_write(A_MODE, K_CMD);
    reg_write(A_PORT, 32'hB5);
    reg_write(A_PORT, 32'h1B5);          // not a page code: ignored
    reg_write(A_MODE, K_DATA);
    reg_write(A_PORT, 32'h01);
    pix_check(0, 40, 7, "R3 page5 col0");
    reg_write(A_MODE, K_DATA ^ 32'h1);   // idle
    reg_write(A_PORT, 32'hFF);
    reg_write(A_PORT, 32'hB3);
    pix_check(1, 40, 7, "R2 idle no store");
    reg_write(A_MODE, K_DATA);
    reg_write(A_PORT, 32'h80);
    pix_check(1, 47, 7, "R2 idle kept page/col");

    // R4 page register in data mode; R5 page code stored as data
    reg_write(A_PAGE, 32'hB7);
    reg_write(A_PORT, 32'h02);
    reg_write(A_PORT, 32'hB1);
    reg_write(A_PAGE, 32'hB8);           // out of range: ignored
    reg_write(A_PORT, 32'h04);
    pix_check(0, 57, 7, "R4 page7 col0");
    pix_check(1, 56, 7, "R5 code as data");
    pix_check(2, 58, 7, "R4 bad code ignored");

    // R6 column overflow
    reg_write(A_PAGE, 32'hB6);
    for (int i = 0; i < 130; i++) reg_write(A_PORT, 32'hFF);
    pix_check(127, 48, 7, "R6 last column");
    pix_check(0, 56, 7, "R6 no spill");
    pix_check(0, 57, 7, "R6 no spill");

    // R8 all brightness levels
    for (int l = 0; l < 8; l++) begin
      pix_check(0, 16, l, "R8 lit level");
      pix_check(0, 17, l, "R8 dark level");
    end

    // R9 back-pressure
    @(negedge clk);
    pix_x = 0; pix_y = 16; bright_level = 7; pix_req_valid = 1; pix_rsp_ready = 0;
    @(negedge clk);
    pix_req_valid = 1; pix_x = 5; pix_y = 5; bright_level = 0;
    check("R9 valid", {31'h0, pix_rsp_valid}, 1);
    check("R9 stalled ready", {31'h0, pix_req_ready}, 0);
    check("R9 colour", {8'h0, pix_rgb}, {8'h0, exp_rgb(1, 7)});
    @(negedge clk);
    check("R9 held valid", {31'h0, pix_rsp_valid}, 1);
    check("R9 held colour", {8'h0, pix_rgb}, {8'h0, exp_rgb(1, 7)});
    pix_req_valid = 0; pix_rsp_ready = 1;
    @(negedge clk);
    check("R9 drained", {31'h0, pix_rsp_valid}, 0);

    // Random mix: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 2) begin
        int k;
        k = int'($urandom % 3);
        reg_write(A_MODE, k == 0 ? K_DATA : k == 1 ? K_CMD : $urandom);
      end else if (r < 4) reg_write(A_PAGE, 32'hB0 + ($urandom % 10));
      else if (r < 9) begin
        if (m_mode == 1) reg_write(A_PORT, 32'hB0 + ($urandom % 10));
        else reg_write(A_PORT, $urandom);
      end else reg_write(12'h1B0, $urandom);
    end
    for (int i = 0; i < 300; i++)
      pix_check(int'($urandom % 128), int'($urandom % 64), int'($urandom % 8),
                "R5 R7 R8 random");
    for (int i = 0; i < 20; i++) begin
      logic [11:0] a;
      a = 12'($urandom);
      rd_addr = a; #1
      check("R10 random read", rd_data, (a == A_STAT) ? 32'h0040_0000 : 32'h0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule